// File: doc/BRIEF.md
# Serial Control Word Loader

This block accepts programming words for a frequency synthesizer over a three-wire serial link made of a data line, a serial clock and a load strobe. The serial lines are brought into the core clock domain through a short synchronizer. Each rising edge seen on the serial clock shifts one data bit into a shift register. The most significant bit arrives first.

The bit shifted in last sits in the least significant position and acts as a routing flag. While the load strobe is high, the shift register contents are copied into one of two holding registers, and the routing flag chooses which one. The reference register holds a 14-bit reference ratio and a prescaler select bit, taken from a 16-bit frame. The main register holds an 11-bit main count and a 7-bit swallow count, taken from a 19-bit frame. The fields of both registers drive the outputs directly, so the divider logic downstream sees stable settings between loads.

Top module: `ctlword_loader`

## Requirements
- R1: After reset, all output fields (`ref_ratio`, `pre_sel`, `main_count`, `swallow_count`) read zero.
- R2: Only a rising edge on `ser_clk` shifts a bit. Changes on `ser_dat` without a rising edge, and falling edges of `ser_clk`, shift nothing.
- R3: Bits are taken most significant first. The last bit shifted is the routing flag, held in shift register bit 0.
- R4: With load high and routing flag 1, the 16-bit frame (first to last: prescaler select, ratio bits 13 down to 0, flag) loads `pre_sel` and `ref_ratio`.
- R5: With load high and routing flag 0, the 19-bit frame (first to last: main count bits 10 down to 0, swallow bits 6 down to 0, flag) loads `main_count` and `swallow_count`.
- R6: A load that targets one holding register leaves the other holding register unchanged.
- R7: While load is low, both holding registers keep their values, including while new bits are shifted in.
- R8: When more bits are sent than a frame needs, only the last 19 bits shifted are kept, so leading extra bits have no effect.
- R9: If load stays high while bits are shifted, the register selected by the current flag follows the shift register. It holds the final frame once load falls.
- R10: The field extremes are carried exactly: ratio 8 and 16383, main count 2047, swallow count 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, level sensitive |
| ref_ratio | output | 14 | Reference divide ratio |
| pre_sel | output | 1 | Prescaler modulus select |
| main_count | output | 11 | Main programmable count |
| swallow_count | output | 7 | Swallow count |

## Verification
The hardest case to reach from the ports is a load strobe held high while bits are still shifting. In that case the routing flag changes from bit to bit, so both holding registers see intermediate words. The bench holds the strobe high across a whole reference frame and then checks that the final frame is what stays latched. It also exercises frames preceded by extra bits, and data toggles with no clock edge followed by a load, so that any stray shift or a wrongly sized window changes a visible field.

// File: rtl/ctlword_loader.sv
module ctlword_loader #(
  parameter int REF_W  = 14,
  parameter int MAIN_W = 11,
  parameter int SWAL_W = 7,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_load,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              pre_sel,
  output logic [MAIN_W-1:0] main_count,
  output logic [SWAL_W-1:0] swallow_count
);
  localparam int FW = MAIN_W + SWAL_W + 1;

  logic [SYNC-1:0] clk_sy, dat_sy, ld_sy;
  logic            clk_d;
  logic [FW-1:0]   sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sy <= '0;
      dat_sy <= '0;
      ld_sy  <= '0;
      clk_d  <= 1'b0;
    end else begin
      clk_sy <= {clk_sy[SYNC-2:0], ser_clk};
      dat_sy <= {dat_sy[SYNC-2:0], ser_dat};
      ld_sy  <= {ld_sy[SYNC-2:0], ser_load};
      clk_d  <= clk_sy[SYNC-1];
    end
  end

  wire sclk = clk_sy[SYNC-1];
  wire sdat = dat_sy[SYNC-1];
  wire sld  = ld_sy[SYNC-1];
  wire rise = sclk & ~clk_d;
  wire ctl  = sr[0];

  always_ff @(posedge clk) begin
    if (!rst_n)    sr <= '0;
    else if (rise) sr <= {sr[FW-2:0], sdat};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          {pre_sel, ref_ratio} <= '0;
    else if (sld && ctl) {pre_sel, ref_ratio} <= sr[REF_W+1:1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           {main_count, swallow_count} <= '0;
    else if (sld && !ctl) {main_count, swallow_count} <= sr[FW-1:1];
  end
endmodule

// File: rtl/ctlword_loader_chk.sv
module ctlword_loader_chk #(
  parameter int REF_W  = 14,
  parameter int MAIN_W = 11,
  parameter int SWAL_W = 7,
  parameter int FW     = MAIN_W + SWAL_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise,
  input logic              ld,
  input logic              ctl,
  input logic [FW-1:0]     sr,
  input logic [REF_W-1:0]  ref_ratio,
  input logic              pre_sel,
  input logic [MAIN_W-1:0] main_count,
  input logic [SWAL_W-1:0] swallow_count
);
  AST_NO_EDGE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(sr)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable({pre_sel, ref_ratio, main_count, swallow_count})); // R7
  AST_REF_SPARES_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ctl) |=> $stable({main_count, swallow_count})); // R6
  AST_MAIN_SPARES_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ctl) |=> $stable({pre_sel, ref_ratio})); // R6
  AST_REF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ctl) |=> ({pre_sel, ref_ratio} == $past(sr[REF_W+1:1]))); // R4
  AST_MAIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ctl) |=> ({main_count, swallow_count} == $past(sr[FW-1:1]))); // R5
endmodule

bind ctlword_loader ctlword_loader_chk #(
  .REF_W(REF_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .ld(sld), .ctl(ctl), .sr(sr),
  .ref_ratio(ref_ratio), .pre_sel(pre_sel),
  .main_count(main_count), .swallow_count(swallow_count)
);

// File: tb/ctlword_loader_test.sv
module ctlword_loader_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_load = 0;
  logic [13:0] ref_ratio;
  logic        pre_sel;
  logic [10:0] main_count;
  logic [6:0]  swallow_count;
  int n_chk = 0, n_bad = 0;
  logic [14:0] exp_ref;
  logic [17:0] exp_main;

  always #(CLK_P/2) clk = ~clk;

  ctlword_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .ref_ratio(ref_ratio), .pre_sel(pre_sel),
    .main_count(main_count), .swallow_count(swallow_count)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b; wait_clk(4);
    ser_clk = 1; wait_clk(4);
    ser_clk = 0; wait_clk(4);
  endtask

  task automatic send_frame(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_load();
    wait_clk(2);
    ser_load = 1; wait_clk(6);
    ser_load = 0; wait_clk(6);
  endtask

  task automatic check_all(input string req);
    chk(req, {17'd0, pre_sel, ref_ratio}, {17'd0, exp_ref});
    chk(req, {14'd0, main_count, swallow_count}, {14'd0, exp_main});
  endtask

  task automatic t_reset();
    exp_ref = '0; exp_main = '0;
    check_all("R1 reset");
  endtask

  task automatic t_ref_load();
    send_frame({16'd0, 1'b1, 14'd1234, 1'b1}, 16);
    pulse_load();
    exp_ref = {1'b1, 14'd1234};
    check_all("R4 R3 R6 reference load");
  endtask

  task automatic t_main_load();
    send_frame({13'd0, 11'd1500, 7'd100, 1'b0}, 19);
    pulse_load();
    exp_main = {11'd1500, 7'd100};
    check_all("R5 R3 R6 main load");
  endtask

  task automatic t_extremes();
    send_frame({16'd0, 1'b0, 14'd8, 1'b1}, 16);
    pulse_load();
    exp_ref = {1'b0, 14'd8};
    check_all("R10 ratio min");
    send_frame({16'd0, 1'b1, 14'd16383, 1'b1}, 16);
    pulse_load();
    exp_ref = {1'b1, 14'd16383};
    check_all("R10 ratio max");
    send_frame({13'd0, 11'd2047, 7'd127, 1'b0}, 19);
    pulse_load();
    exp_main = {11'd2047, 7'd127};
    check_all("R10 main and swallow max");
  endtask

  task automatic t_hold_and_noedge();
    send_frame({13'd0, 11'd300, 7'd45, 1'b0}, 19);
    check_all("R7 hold while shifting without load");
    for (int i = 0; i < 6; i++) begin
      ser_dat = i[0]; wait_clk(3);
    end
    ser_dat = 1; wait_clk(3);
    ser_clk = 0; wait_clk(3);
    check_all("R7 hold after data toggles");
    pulse_load();
    exp_main = {11'd300, 7'd45};
    check_all("R2 no shift without rising edge");
  endtask

  task automatic t_long_frame();
    send_frame(32'h1f, 5);
    send_frame({13'd0, 11'd77, 7'd3, 1'b0}, 19);
    pulse_load();
    exp_main = {11'd77, 7'd3};
    check_all("R8 leading extra bits ignored");
    send_frame(32'h7, 3);
    send_frame({16'd0, 1'b0, 14'd555, 1'b1}, 16);
    pulse_load();
    exp_ref = {1'b0, 14'd555};
    chk("R8 reference after extra bits", {17'd0, pre_sel, ref_ratio}, {17'd0, exp_ref});
  endtask

  task automatic t_level_load();
    ser_load = 1; wait_clk(4);
    send_frame({16'd0, 1'b1, 14'd4321, 1'b1}, 16);
    wait_clk(4);
    ser_load = 0; wait_clk(6);
    exp_ref = {1'b1, 14'd4321};
    chk("R9 load held high during shift", {17'd0, pre_sel, ref_ratio}, {17'd0, exp_ref});
    send_bit(1'b0);
    wait_clk(4);
    chk("R9 R7 stays after load falls", {17'd0, pre_sel, ref_ratio}, {17'd0, exp_ref});
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1;
    wait_clk(2);
    t_reset();
    t_ref_load();
    t_main_load();
    t_extremes();
    t_hold_and_noedge();
    t_long_frame();
    t_level_load();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule